// File: doc/BRIEF.md
# External Event Counter Timer Channel

One timer channel that counts edges on an external input pin. The pin is brought into the
system clock domain by a two-flop synchronizer. An optional noise filter can follow it. The
result then goes to an edge detector, and a software-selected polarity decides which edges
count. Every qualifying edge lowers a 16-bit count register by one. When a count would reach
zero, the channel reloads from a software-written reload register, keeps running and emits a
one-cycle interrupt pulse.

Software drives the channel through a small word-addressed register port. It writes the reload
value, and it sets the edge polarity and filter enable in a control register. Two self-clearing
trigger bits in the same control register start and stop the channel. An enable status bit and
the live count can be read back at any time. A single clock-enable input stands in for the
unit-level clock gate. While it is low, the channel holds every piece of state.

Top module: `evt_cnt_top`

## Requirements
- R1: After reset the reload register, count register, control fields, enable status and interrupt output are all 0.
- R2: A control write (address 2) with bit 0 set and bit 1 clear sets the enable status (control read bit 8) and copies the reload register (address 0) into the count register (address 1). Trigger bits 0 and 1 always read back as 0.
- R3: While enabled, each qualifying edge lowers the count by one. Control bits [4:3] select the edges: 0 counts rising edges, 1 counts falling edges, and 2 or 3 count both.
- R4: A qualifying edge that arrives when the count is 1 or 0 loads the reload value instead of decrementing. It also drives `irq_o` high for exactly one cycle, so a reload value of 0 interrupts on every edge.
- R5: A control write with bit 1 set clears the enable status. The count then keeps its value and edges are ignored.
- R6: When a single control write sets both bit 0 and bit 1, the stop wins: the channel ends up disabled and the count is not reloaded.
- R7: Writing the reload register while counting leaves the current count untouched. The new value is used at the next reload.
- R8: Reading the count register does not disturb counting, and writes to address 1 are ignored.
- R9: Control bit 2 enables the filter. With the filter on, a one-cycle pulse on the pin is rejected and a level held for at least two samples is counted. With the filter off, a one-cycle pulse is counted.
- R10: While `clk_en_i` is low, register writes and pin edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Unit clock enable; all state holds while low |
| evt_i | input | 1 | Asynchronous external event pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 reload, 1 count, 2 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| enabled_o | output | 1 | Channel enable status |
| irq_o | output | 1 | One-cycle interrupt pulse on reload |

## Verification
The assertions assume that the event pin holds each level for at least two system clocks.
Under that assumption detected edges are isolated and the interrupt can never stay high for
two consecutive cycles. The stimulus keeps every pin level for several clocks, except for the
deliberate one-cycle glitches in the filter scenario. Those glitches only need the filter to
reject them or the edge detector to count them once. The assertions also assume that register
writes arrive as single-cycle strobes. Every bench write is one cycle long, driven on the
falling clock edge.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    ADDR_RELOAD = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned CTRL_NF_BIT    = 2;
  localparam int unsigned CTRL_ESEL_LSB  = 3;
  localparam int unsigned CTRL_EN_BIT    = 8;
endpackage

// File: rtl/evt_sync_filter.sv
module evt_sync_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_i,
  input  logic nf_en_i,
  input  logic pin_i,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level_q;
  logic                   sync_lvl;

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      level_q <= 1'b0;
    end else if (clk_en_i) begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_lvl;
      if (!nf_en_i) begin
        level_q <= sync_lvl;
      end else if (sync_lvl == prev_q) begin
        // level accepted only after two matching samples
        level_q <= sync_lvl;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_cnt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clk_en_i,
  input  logic      level_i,
  input  edge_sel_e esel_i,
  output logic      edge_o
);
  logic level_d_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       level_d_q <= 1'b0;
    else if (clk_en_i) level_d_q <= level_i;
  end

  assign rise = level_i & ~level_d_q;
  assign fall = ~level_i & level_d_q;

  always_comb begin
    unique case (esel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      default:   edge_o = rise | fall;
    endcase
    edge_o = edge_o & clk_en_i;
  end
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             edge_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             enabled_o,
  output logic             irq_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic             en_q;
  logic             irq_q;
  logic             wrap;

  assign wrap = (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else if (clk_en_i) begin
      irq_q <= 1'b0;
      if (stop_i) begin
        en_q <= 1'b0;
      end else if (start_i) begin
        en_q  <= 1'b1;
        cnt_q <= reload_i;
      end else if (en_q && edge_i) begin
        if (wrap) begin
          cnt_q <= reload_i;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign enabled_o = en_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/evt_cnt_top.sv
module evt_cnt_top
  import evt_cnt_pkg::*;
#(
  parameter int unsigned WIDTH       = CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             evt_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  output logic             enabled_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] reload_q;
  logic             nf_q;
  edge_sel_e        esel_q;
  logic             ctrl_we;
  logic             start, stop;
  logic             level, edge_det;
  logic [WIDTH-1:0] cnt;

  assign ctrl_we = reg_we_i && clk_en_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
  assign start   = ctrl_we && reg_wdata_i[CTRL_START_BIT];
  assign stop    = ctrl_we && reg_wdata_i[CTRL_STOP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      nf_q     <= 1'b0;
      esel_q   <= EDGE_RISE;
    end else if (clk_en_i && reg_we_i) begin
      if (reg_addr_e'(reg_addr_i) == ADDR_RELOAD) reload_q <= reg_wdata_i;
      if (ctrl_we) begin
        nf_q   <= reg_wdata_i[CTRL_NF_BIT];
        esel_q <= edge_sel_e'(reg_wdata_i[CTRL_ESEL_LSB +: 2]);
      end
    end
  end

  evt_sync_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (clk_en_i),
    .nf_en_i  (nf_q),
    .pin_i    (evt_i),
    .level_o  (level)
  );

  evt_edge_det u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (clk_en_i),
    .level_i  (level),
    .esel_i   (esel_q),
    .edge_o   (edge_det)
  );

  evt_down_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_en_i  (clk_en_i),
    .start_i   (start),
    .stop_i    (stop),
    .edge_i    (edge_det),
    .reload_i  (reload_q),
    .cnt_o     (cnt),
    .enabled_o (enabled_o),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_RELOAD: reg_rdata_o = reload_q;
      ADDR_COUNT:  reg_rdata_o = cnt;
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_NF_BIT]          = nf_q;
        reg_rdata_o[CTRL_ESEL_LSB +: 2]   = esel_q;
        reg_rdata_o[CTRL_EN_BIT]          = enabled_o;
      end
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_cnt_chk.sv
module evt_cnt_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [WIDTH-1:0] reg_wdata_i,
  input logic             enabled_o,
  input logic             irq_o,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] reload_q
);
  logic ctrl_wr;
  assign ctrl_wr = clk_en_i && reg_we_i && (reg_addr_i == 2'd2);

  // R2
  start_sets_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[0] && !reg_wdata_i[1]) |=> (enabled_o && cnt == $past(reload_q)));

  // R5 R6
  stop_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[1]) |=> !enabled_o);

  // R5
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enabled_o && !(ctrl_wr && reg_wdata_i[0])) |=> $stable(cnt));

  // R4
  irq_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(enabled_o) && cnt == $past(reload_q)));

  // R4
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10
  gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(cnt) && $stable(enabled_o) && $stable(reload_q) && !irq_o));
endmodule

bind evt_cnt_top evt_cnt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk_en_i    (clk_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .enabled_o   (enabled_o),
  .irq_o       (irq_o),
  .cnt         (cnt),
  .reload_q    (reload_q)
);

// File: tb/tb_evt_cnt_top.sv
module tb_evt_cnt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  logic        evt_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        enabled_o;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_seen = 0;
  int irq_run = 0;
  int irq_max_run = 0;

  always #4 clk_i = ~clk_i;

  evt_cnt_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i), .evt_i(evt_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .enabled_o(enabled_o), .irq_o(irq_o)
  );

  always @(negedge clk_i) begin
    if (irq_o) begin
      irq_seen++;
      irq_run++;
      if (irq_run > irq_max_run) irq_max_run = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pin(input logic v);
    @(negedge clk_i);
    evt_i = v;
    repeat (7) @(negedge clk_i);
  endtask

  task automatic expect_cnt(input int exp, input string req);
    logic [15:0] d;
    rd(2'd1, d);
    check(d == exp[15:0], req, d, exp);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); check(d == 0, "R1 reload", d, 0);
    rd(2'd1, d); check(d == 0, "R1 count", d, 0);
    rd(2'd2, d); check(d == 0, "R1 ctrl", d, 0);
    check(!irq_o && !enabled_o, "R1 irq/en", {irq_o, enabled_o}, 0);
  endtask

  task automatic t_start;
    logic [15:0] d;
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); check(d == 16'h0100, "R2 ctrl readback", d, 16'h0100);
    expect_cnt(3, "R2 load");
  endtask

  task automatic t_rise_reload;
    int base;
    base = irq_seen;
    pin(1); pin(0); expect_cnt(2, "R3 rise");
    pin(1); pin(0); expect_cnt(1, "R3 rise");
    pin(1); expect_cnt(3, "R4 reload");
    pin(0);
    check(irq_seen == base + 1, "R4 irq count", irq_seen - base, 1);
  endtask

  task automatic t_fall_both;
    int base;
    wr(2'd2, 16'h0008);
    pin(1); expect_cnt(3, "R3 fall ignores rise");
    pin(0); expect_cnt(2, "R3 fall");
    wr(2'd2, 16'h0010);
    base = irq_seen;
    pin(1); expect_cnt(1, "R3 both rise");
    pin(0); expect_cnt(3, "R4 both reload");
    check(irq_seen == base + 1, "R4 irq both", irq_seen - base, 1);
  endtask

  task automatic t_data_write;
    logic [15:0] d;
    wr(2'd0, 16'd5);
    expect_cnt(3, "R7 count untouched");
    pin(1); pin(0); expect_cnt(1, "R7 count on");
    pin(1); expect_cnt(5, "R7 new reload");
    wr(2'd1, 16'hFFFF);
    expect_cnt(5, "R8 count write ignored");
    rd(2'd1, d); rd(2'd1, d);
    pin(0); expect_cnt(4, "R8 read no disturb");
  endtask

  task automatic t_stop;
    wr(2'd2, 16'h0012);
    check(!enabled_o, "R5 stop", enabled_o, 0);
    pin(1); pin(0);
    expect_cnt(4, "R5 hold");
    wr(2'd0, 16'd7);
    wr(2'd2, 16'h0013);
    check(!enabled_o, "R6 stop wins en", enabled_o, 0);
    expect_cnt(4, "R6 no reload");
    wr(2'd2, 16'h0011);
    expect_cnt(7, "R2 restart load");
  endtask

  task automatic t_zero_reload;
    int base;
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0011);
    base = irq_seen;
    pin(1); pin(0);
    expect_cnt(0, "R4 zero reload");
    check(irq_seen == base + 2, "R4 irq every edge", irq_seen - base, 2);
  endtask

  task automatic t_filter;
    wr(2'd0, 16'd4);
    wr(2'd2, 16'h0005);
    expect_cnt(4, "R9 start");
    @(negedge clk_i) evt_i = 1'b1;
    @(negedge clk_i) evt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    expect_cnt(4, "R9 glitch rejected");
    pin(1); pin(0);
    expect_cnt(3, "R9 stable counted");
    wr(2'd2, 16'h0000);
    @(negedge clk_i) evt_i = 1'b1;
    @(negedge clk_i) evt_i = 1'b0;
    repeat (8) @(negedge clk_i);
    expect_cnt(2, "R9 glitch counted unfiltered");
  endtask

  task automatic t_gate;
    logic [15:0] d;
    @(negedge clk_i) clk_en_i = 1'b0;
    wr(2'd0, 16'd9);
    wr(2'd2, 16'h0002);
    evt_i = 1'b1; repeat (6) @(negedge clk_i);
    evt_i = 1'b0; repeat (6) @(negedge clk_i);
    clk_en_i = 1'b1;
    repeat (6) @(negedge clk_i);
    rd(2'd0, d); check(d == 4, "R10 reload held", d, 4);
    check(enabled_o, "R10 enable held", enabled_o, 1);
    expect_cnt(2, "R10 count held");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_start();
    t_rise_reload();
    t_fall_both();
    t_data_write();
    t_stop();
    t_zero_reload();
    t_filter();
    t_gate();
    check(irq_max_run == 1, "R4 pulse width", irq_max_run, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule